// File: doc/BRIEF.md
# Segment Window Fetch Controller

This block takes in one square image segment (40 by 40 pixels of 8 bits by default), one pixel at a time, and keeps it in a single-port pixel memory. When the segment is complete, the block visits every pixel that has all eight neighbours inside the segment. For each such centre it reads the nine pixels of the surrounding 3x3 neighbourhood from memory, one read per cycle. Each word goes into one register of a nine-register window bank, and a decoder driven by a select code picks that register. Once the bank is full, the block gives the downstream arithmetic unit a one-cycle start pulse. It then holds the window steady until that unit reports that it is finished. Pixels on the segment's edge are never used as centres.

Pixels arrive on a valid/ready stream. The block raises `pix_ready` only while it is collecting a segment. A word moves only in a cycle where `pix_valid` and `pix_ready` are both high, and the sender must hold its word until that happens. Between the last accepted pixel and the end of the segment's scan, `pix_ready` stays low and `pix_valid` is ignored. After the last window has been released, the block pulses `seg_done` and then accepts the next segment.

Top module: `seg_window_fetch`

## Requirements
- R1: While collecting, the block holds `pix_ready` high. Accepted pixels are stored in raster order: the n-th accepted word (n from 0) is the pixel at row n/40, column n%40.
- R2: From the cycle after the 1600th accepted pixel until the segment's `seg_done` cycle, `pix_ready` is low and a high `pix_valid` stores nothing.
- R3: Window centres are visited in raster order over rows 1..38 and columns 1..38. Each segment yields exactly 1444 windows, and no edge pixel is ever a centre.
- R4: Window register k (k = 3*r + c, with r and c in 0..2) sits at `win_flat[8*k +: 8]` and holds the pixel at row `row+r-1`, column `col+c-1` of the current centre (`row`, `col`).
- R5: `calc_start` is a one-cycle pulse. It is high in the 11th cycle after the cycle in which the last pixel was accepted or a `calc_done` was taken.
- R6: `win_flat` does not change from the `calc_start` cycle through the cycle in which `calc_done` is taken.
- R7: `calc_done` is taken only in cycles after a `calc_start` pulse and before the next fetch. A `calc_done` that is high in any other cycle, including the start cycle itself, has no effect.
- R8: `seg_done` is high for one cycle, in the cycle after the 1444th `calc_done` is taken. `pix_ready` is high in the cycle after that.
- R9: After reset, `pix_ready` is high, `calc_start` and `seg_done` are low, and the next accepted pixel is stored as pixel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | Pixel stream word present |
| pix_ready | output | 1 | Block can accept a pixel |
| pix_data | input | 8 | Pixel value |
| calc_start | output | 1 | Window is complete; start the arithmetic |
| calc_done | input | 1 | Arithmetic finished with the current window |
| win_flat | output | 72 | Nine window registers, register k in bits 8k+7..8k |
| seg_done | output | 1 | Every window of the segment has been released |

## Verification
The bench loads segments with several pixel patterns, with and without gaps in `pix_valid`. It compares every one of the 1444 windows against neighbourhoods computed from its own pixel function. An off-by-one in the interior bounds, a wrong row-wrap step or a select code that is not delayed to match the read latency would therefore show up as a wrong window value. It measures the gap from each release to the next start, and it raises `calc_done` during a fetch and in the start cycle. A design that takes `calc_done` outside its waiting phase would start the next window early. The bench holds `pix_valid` high with junk data while a window is waiting. If the block took those words, the next segment's pixels would be shifted. Finally, it resets the block in the middle of a load and checks that the following segment lands at address 0.

// File: rtl/sw_pkg.sv
package sw_pkg;

  localparam int SW_TAPS = 9;

  typedef enum logic [2:0] {
    ST_LOAD,
    ST_FETCH,
    ST_DRAIN,
    ST_START,
    ST_WAIT,
    ST_DONE
  } sw_state_e;

endpackage

// File: rtl/sw_pixel_ram.sv
module sw_pixel_ram #(
  parameter int DEPTH = 1600,
  parameter int DW    = 8,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // single port: a write cycle also returns the old word, which nobody uses
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/sw_scan_gen.sv
module sw_scan_gen #(
  parameter int DIM   = 40,
  parameter int AW    = 11,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pos_clr,
  input  logic             pos_step,
  input  logic             elem_step,
  output logic [SEL_W-1:0] elem,
  output logic             elem_last,
  output logic             pos_last,
  output logic [AW-1:0]    rd_addr
);

  localparam int PW = $clog2(DIM);
  localparam logic [PW-1:0]    EDGE_LO  = PW'(1);
  localparam logic [PW-1:0]    EDGE_HI  = PW'(DIM - 2);
  localparam logic [SEL_W-1:0] TAP_END  = SEL_W'(sw_pkg::SW_TAPS - 1);
  localparam logic [AW-1:0]    ROW_JUMP = AW'(DIM - 2);
  localparam logic [AW-1:0]    WRAP_INC = AW'(3);

  logic [PW-1:0]    row_q, col_q;
  logic [AW-1:0]    base_q, off_q;
  logic [SEL_W-1:0] elem_q;
  logic [1:0]       tcol_q;

  assign pos_last  = (row_q == EDGE_HI) && (col_q == EDGE_HI);
  assign elem_last = (elem_q == TAP_END);
  assign elem      = elem_q;
  assign rd_addr   = base_q + off_q;

  // window centre and top-left corner address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= EDGE_LO;
      col_q  <= EDGE_LO;
      base_q <= '0;
    end else if (pos_clr) begin
      row_q  <= EDGE_LO;
      col_q  <= EDGE_LO;
      base_q <= '0;
    end else if (pos_step) begin
      if (col_q == EDGE_HI) begin
        col_q  <= EDGE_LO;
        row_q  <= row_q + PW'(1);
        base_q <= base_q + WRAP_INC;
      end else begin
        col_q  <= col_q + PW'(1);
        base_q <= base_q + AW'(1);
      end
    end
  end

  // element inside the window, with its offset from the corner
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_q <= '0;
      tcol_q <= '0;
      off_q  <= '0;
    end else if (elem_step) begin
      if (elem_last) begin
        elem_q <= '0;
        tcol_q <= '0;
        off_q  <= '0;
      end else begin
        elem_q <= elem_q + SEL_W'(1);
        if (tcol_q == 2'd2) begin
          tcol_q <= '0;
          off_q  <= off_q + ROW_JUMP;
        end else begin
          tcol_q <= tcol_q + 2'd1;
          off_q  <= off_q + AW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/sw_win_bank.sv
module sw_win_bank #(
  parameter int DW    = 8,
  parameter int TAPS  = 9,
  parameter int SEL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   sel,
  input  logic [DW-1:0]      din,
  output logic [TAPS*DW-1:0] win_flat
);

  logic [TAPS-1:0] hit;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic [DW-1:0] tap_q;

    assign hit[k] = wr_en && (sel == SEL_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tap_q <= '0;
      else if (hit[k]) tap_q <= din;
    end

    assign win_flat[k*DW +: DW] = tap_q;
  end

endmodule

// File: rtl/seg_window_fetch.sv
module seg_window_fetch #(
  parameter int DIM   = 40,
  parameter int PIX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pix_valid,
  output logic                 pix_ready,
  input  logic [PIX_W-1:0]     pix_data,
  output logic                 calc_start,
  input  logic                 calc_done,
  output logic [9*PIX_W-1:0]   win_flat,
  output logic                 seg_done
);
  import sw_pkg::*;

  localparam int PIXELS = DIM * DIM;
  localparam int AW     = $clog2(PIXELS);
  localparam int SEL_W  = $clog2(SW_TAPS);
  localparam logic [AW-1:0] PTR_END = AW'(PIXELS - 1);

  sw_state_e state_q, state_d;

  logic [AW-1:0]    wr_ptr_q;
  logic             accept, load_end, issue;
  logic             pos_step, pos_clr;
  logic [SEL_W-1:0] elem;
  logic             elem_last, pos_last;
  logic [AW-1:0]    rd_addr, mem_addr;
  logic [PIX_W-1:0] mem_q;
  logic [SEL_W-1:0] sel_q;
  logic             ld_q;

  assign pix_ready  = (state_q == ST_LOAD);
  assign accept     = pix_ready && pix_valid;
  assign load_end   = accept && (wr_ptr_q == PTR_END);
  assign issue      = (state_q == ST_FETCH);
  assign pos_step   = (state_q == ST_WAIT) && calc_done && !pos_last;
  assign pos_clr    = (state_q == ST_DONE);
  assign calc_start = (state_q == ST_START);
  assign seg_done   = (state_q == ST_DONE);
  assign mem_addr   = issue ? rd_addr : wr_ptr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOAD:  if (load_end)  state_d = ST_FETCH;
      ST_FETCH: if (elem_last) state_d = ST_DRAIN;
      ST_DRAIN: state_d = ST_START;
      ST_START: state_d = ST_WAIT;
      ST_WAIT:  if (calc_done) state_d = pos_last ? ST_DONE : ST_FETCH;
      ST_DONE:  state_d = ST_LOAD;
      default:  state_d = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LOAD;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wr_ptr_q <= '0;
    else if (accept) wr_ptr_q <= load_end ? '0 : wr_ptr_q + AW'(1);
  end

  // select code follows the read by one cycle to meet the returning word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      ld_q  <= 1'b0;
    end else begin
      sel_q <= elem;
      ld_q  <= issue;
    end
  end

  sw_scan_gen #(.DIM(DIM), .AW(AW), .SEL_W(SEL_W)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .pos_clr   (pos_clr),
    .pos_step  (pos_step),
    .elem_step (issue),
    .elem      (elem),
    .elem_last (elem_last),
    .pos_last  (pos_last),
    .rd_addr   (rd_addr)
  );

  sw_pixel_ram #(.DEPTH(PIXELS), .DW(PIX_W), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (accept),
    .addr  (mem_addr),
    .wdata (pix_data),
    .rdata (mem_q)
  );

  sw_win_bank #(.DW(PIX_W), .TAPS(SW_TAPS), .SEL_W(SEL_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ld_q),
    .sel      (sel_q),
    .din      (mem_q),
    .win_flat (win_flat)
  );

endmodule

// File: rtl/seg_window_fetch_chk.sv
module seg_window_fetch_chk #(
  parameter int DIM   = 40,
  parameter int PIX_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pix_ready,
  input logic               calc_start,
  input logic               calc_done,
  input logic               seg_done,
  input logic [9*PIX_W-1:0] win_flat
);

  localparam int WINDOWS = (DIM - 2) * (DIM - 2);
  localparam int CW      = $clog2(WINDOWS + 1);

  logic          busy_q;
  logic [CW-1:0] starts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  busy_q <= 1'b0;
    else if (calc_start)         busy_q <= 1'b1;
    else if (busy_q && calc_done) busy_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          starts_q <= '0;
    else if (seg_done)   starts_q <= '0;
    else if (calc_start) starts_q <= starts_q + CW'(1);
  end

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    calc_start |=> !calc_start);

  // R6
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> $stable(win_flat));

  // R2
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q || calc_start) |-> !pix_ready);

  // R3
  start_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    calc_start |-> (starts_q < CW'(WINDOWS)));

  // R8
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_done |-> (starts_q == CW'(WINDOWS)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_done |=> (pix_ready && !seg_done));

endmodule

bind seg_window_fetch seg_window_fetch_chk #(.DIM(DIM), .PIX_W(PIX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_ready  (pix_ready),
  .calc_start (calc_start),
  .calc_done  (calc_done),
  .seg_done   (seg_done),
  .win_flat   (win_flat)
);

// File: tb/sim_seg_window_fetch.sv
`timescale 1ns/1ps
module sim_seg_window_fetch;

  localparam int DIM  = 40;
  localparam int NPIX = DIM * DIM;
  localparam int WINS = (DIM - 2) * (DIM - 2);
  localparam int NV   = 3;
  // per segment: pixel multiplier, offset, done delay, valid gaps, junk while waiting, stray done
  localparam int V_MULT [NV] = '{7, 13, 1};
  localparam int V_ADD  [NV] = '{3, 91, 200};
  localparam int V_DLY  [NV] = '{0, 2, 1};
  localparam int V_GAP  [NV] = '{0, 1, 0};
  localparam int V_JUNK [NV] = '{0, 1, 0};
  localparam int V_SPUR [NV] = '{0, 0, 1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [7:0]  pix_data = '0;
  logic        calc_start;
  logic        calc_done = 1'b0;
  logic [71:0] win_flat;
  logic        seg_done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  seg_window_fetch #(.DIM(DIM), .PIX_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .calc_start(calc_start), .calc_done(calc_done),
    .win_flat(win_flat), .seg_done(seg_done)
  );

  function automatic logic [7:0] pixf(int m, int a, int idx);
    return 8'((idx * m + a + (idx >> 6)) & 255);
  endfunction

  function automatic logic [71:0] expwin(int m, int a, int row, int col);
    logic [71:0] w;
    for (int k = 0; k < 9; k++)
      w[k*8 +: 8] = pixf(m, a, (row + k / 3 - 1) * DIM + (col + k % 3 - 1));
    return w;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [71:0] act, logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load_seg(int m, int a, bit gap);
    int idx = 0;
    int cyc = 0;
    while (idx < NPIX) begin
      @(negedge clk);
      cyc++;
      if (gap && (cyc % 4 == 0)) pix_valid = 1'b0;
      else begin
        pix_valid = 1'b1;
        pix_data  = pixf(m, a, idx);
        if (pix_ready) idx++;
      end
    end
  endtask

  task automatic run_seg(int v);
    load_seg(V_MULT[v], V_ADD[v], V_GAP[v] != 0);
    for (int w = 0; w < WINS; w++) begin
      int n;
      int row;
      int col;
      logic [71:0] ew;
      n = 0;
      row = 1 + w / (DIM - 2);
      col = 1 + w % (DIM - 2);
      ew = expwin(V_MULT[v], V_ADD[v], row, col);
      do begin
        @(negedge clk);
        n++;
        pix_valid = 1'b0;
        calc_done = (V_SPUR[v] != 0) && (n == 4);   // R7: stray done during fetch
        if (w == 0 && n == 1)
          chk(pix_ready == 1'b0, "R2", "ready after last pixel", 72'(pix_ready), 72'(0));
      end while (!calc_start && n < 40);
      chk(n == 11, "R5", "start latency", 72'(n), 72'(11));
      // R3 raster interior order and R4 register layout
      chk(win_flat == ew, "R4", $sformatf("window r%0d c%0d", row, col), win_flat, ew);
      if (V_SPUR[v] != 0) calc_done = 1'b1;          // R7: done in the start cycle
      for (int d = 0; d < V_DLY[v]; d++) begin
        @(negedge clk);
        calc_done = 1'b0;
        if (V_JUNK[v] != 0) begin
          pix_valid = 1'b1;
          pix_data  = 8'hEE;
        end
        if (d == 0)
          chk(calc_start == 1'b0, "R5", "start width", 72'(calc_start), 72'(0));
      end
      @(negedge clk);
      if (V_DLY[v] != 0)
        chk(win_flat == ew, "R6", "window held", win_flat, ew);
      pix_valid = 1'b0;
      calc_done = 1'b1;
    end
    @(negedge clk);
    calc_done = 1'b0;
    chk(seg_done == 1'b1, "R8", "seg_done after last release", 72'(seg_done), 72'(1));
    chk(calc_start == 1'b0, "R3", "no extra window", 72'(calc_start), 72'(0));
    @(negedge clk);
    chk(seg_done == 1'b0, "R8", "seg_done width", 72'(seg_done), 72'(0));
    chk(pix_ready == 1'b1, "R8", "ready for next segment", 72'(pix_ready), 72'(1));
    chk(pix_ready == 1'b1, "R1", "ready while collecting", 72'(pix_ready), 72'(1));
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pix_ready == 1'b1, "R9", "ready out of reset", 72'(pix_ready), 72'(1));
    chk(calc_start == 1'b0, "R9", "start out of reset", 72'(calc_start), 72'(0));
    chk(seg_done == 1'b0, "R9", "done out of reset", 72'(seg_done), 72'(0));

    for (int v = 0; v < NV; v++) run_seg(v);

    // reset during a load: the next segment must start at pixel 0
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      pix_valid = 1'b1;
      pix_data  = 8'(i * 3);
    end
    @(negedge clk);
    pix_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pix_ready == 1'b1, "R9", "ready after mid-load reset", 72'(pix_ready), 72'(1));
    chk(calc_start == 1'b0, "R9", "start after mid-load reset", 72'(calc_start), 72'(0));
    chk(seg_done == 1'b0, "R9", "done after mid-load reset", 72'(seg_done), 72'(0));
    run_seg(0);
    finish_run();
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

endmodule